// File: doc/BRIEF.md
# Toll Lane Gate Controller

This block decides, cycle by cycle, whether a toll-lane barrier should lift. Four sampled inputs arrive each clock: a vehicle-presence sense, a ten-cent coin pulse, a twenty-five-cent coin pulse and an electronic-tag detection. The single gate command is a Mealy output. It is formed combinationally from the stored credit state and the present inputs, so the barrier is commanded in the same cycle as the payment event that completes the toll of 35 cents.

Credit is held as one of five encoded states. Credits of 25 and 30 cents lead to the same future behaviour, because any further coin reaches the toll from either of them, so they share one state. A tag read while a vehicle is present opens the gate at once and needs no coins. After every opening the machine drops back to its idle state and waits for the next vehicle. Each input combination has exactly one defined response in each state.

Top module: `toll_gate_ctrl`

## Requirements
- R1: An active-low asynchronous reset forces the state to idle (state code 3'b000) without waiting for a clock edge, and gate_o stays low for as long as reset is held.
- R2: In idle with car_i low, the coin and tag inputs have no effect: the state stays 3'b000 and gate_o stays low.
- R3: With car_i high and no coin or tag, idle moves to the car-waiting state 3'b001, and any credit state keeps its code on the next edge (a self-loop).
- R4: Credit codes are 3'b001 = 0 cents, 3'b010 = 10 cents, 3'b011 = 20 cents and 3'b100 = 25 or 30 cents. A lone dime_i adds 10 cents and a lone quarter_i adds 25 cents. Idle with car_i high counts as 0 cents of credit.
- R5: When dime_i and quarter_i are both high in one cycle, only 25 cents is credited.
- R6: When a coin brings the credit to 35 cents or more, gate_o is high in that same cycle and the next state is idle.
- R7: With car_i high, tag_i forces gate_o high in that cycle and the next state to idle, whatever the credit and coin inputs are.
- R8: 20 cents plus a dime gives state 3'b100. From that state a single dime opens the gate.
- R9: In any non-idle state, car_i low returns the machine to idle on the next edge with gate_o low. All credit is discarded and coins and tag in that cycle are ignored.
- R10: gate_o is never high while car_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; inputs are sampled and the state advances on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| car_i | input | 1 | A vehicle is present in the lane |
| dime_i | input | 1 | Ten-cent coin accepted this cycle |
| quarter_i | input | 1 | Twenty-five-cent coin accepted this cycle |
| tag_i | input | 1 | Valid electronic tag read this cycle |
| gate_o | output | 1 | Lift-barrier command (Mealy, combinational from state and inputs) |
| state_o | output | 3 | Current credit-state code |

## Verification
Some properties are checked on every cycle: the gate never rises without a vehicle, every opening is followed by idle, a tag with a vehicle always opens, a departure always returns to idle, an idle lane with no vehicle stays idle, credit holds while there is no payment input, and the state code is always legal. The coin arithmetic can only be shown by the directed scenarios. These cover the exact sequence of credit codes, the dime-and-quarter rule that credits only the quarter, the merged 25/30 state, and the thresholds at which a coin does or does not reach the toll. The scenarios also check that credit is lost when a vehicle leaves, and they apply a reset in the middle of a payment.

// File: rtl/toll_pkg.sv
package toll_pkg;

  localparam int STATE_W = 3;

  // Codes are externally visible on state_o; keep them stable.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'b000,
    ST_CAR0 = 3'b001,
    ST_C10  = 3'b010,
    ST_C20  = 3'b011,
    ST_C25  = 3'b100   // 25 or 30 cents: same future behaviour
  } toll_state_e;

endpackage

// File: rtl/toll_coin_value.sv
module toll_coin_value #(
  parameter int CREDIT_W      = 6,
  parameter int DIME_CENTS    = 10,
  parameter int QUARTER_CENTS = 25
) (
  input  logic                dime_i,
  input  logic                quarter_i,
  output logic [CREDIT_W-1:0] add_o
);

  // Quarter wins when both coins are flagged in one cycle.
  always_comb begin
    if (quarter_i)   add_o = CREDIT_W'(QUARTER_CENTS);
    else if (dime_i) add_o = CREDIT_W'(DIME_CENTS);
    else             add_o = '0;
  end

endmodule

// File: rtl/toll_next_state.sv
module toll_next_state
  import toll_pkg::*;
#(
  parameter int CREDIT_W      = 6,
  parameter int DIME_CENTS    = 10,
  parameter int QUARTER_CENTS = 25,
  parameter int TOLL_CENTS    = 35
) (
  input  toll_state_e         state_q,
  input  logic                car_i,
  input  logic                tag_i,
  input  logic [CREDIT_W-1:0] add_i,
  output toll_state_e         state_d,
  output logic                gate_o
);

  localparam logic [CREDIT_W-1:0] DimeC    = CREDIT_W'(DIME_CENTS);
  localparam logic [CREDIT_W-1:0] TwoDimeC = CREDIT_W'(2 * DIME_CENTS);
  localparam logic [CREDIT_W-1:0] QuartC   = CREDIT_W'(QUARTER_CENTS);
  localparam logic [CREDIT_W-1:0] TollC    = CREDIT_W'(TOLL_CENTS);

  logic [CREDIT_W-1:0] credit_cur;
  logic [CREDIT_W-1:0] credit_sum;
  toll_state_e         sum_state;

  always_comb begin
    unique case (state_q)
      ST_C10:  credit_cur = DimeC;
      ST_C20:  credit_cur = TwoDimeC;
      ST_C25:  credit_cur = QuartC;
      default: credit_cur = '0;
    endcase
  end

  assign credit_sum = credit_cur + add_i;

  always_comb begin
    if (credit_sum >= QuartC)        sum_state = ST_C25;
    else if (credit_sum >= TwoDimeC) sum_state = ST_C20;
    else if (credit_sum >= DimeC)    sum_state = ST_C10;
    else                             sum_state = ST_CAR0;
  end

  always_comb begin
    gate_o  = 1'b0;
    state_d = sum_state;
    if (!car_i) begin
      state_d = ST_IDLE;
    end else if (tag_i || (credit_sum >= TollC)) begin
      gate_o  = 1'b1;
      state_d = ST_IDLE;
    end
  end

endmodule

// File: rtl/toll_state_reg.sv
module toll_state_reg
  import toll_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  toll_state_e state_d,
  output toll_state_e state_q
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/toll_gate_ctrl.sv
module toll_gate_ctrl
  import toll_pkg::*;
#(
  parameter int DIME_CENTS    = 10,
  parameter int QUARTER_CENTS = 25,
  parameter int TOLL_CENTS    = 35
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               car_i,
  input  logic               dime_i,
  input  logic               quarter_i,
  input  logic               tag_i,
  output logic               gate_o,
  output logic [STATE_W-1:0] state_o
);

  localparam int CREDIT_W = $clog2(TOLL_CENTS + QUARTER_CENTS + 1);

  logic [CREDIT_W-1:0] coin_add;
  toll_state_e         state_q;
  toll_state_e         state_d;
  logic                gate_raw;

  toll_coin_value #(
    .CREDIT_W      (CREDIT_W),
    .DIME_CENTS    (DIME_CENTS),
    .QUARTER_CENTS (QUARTER_CENTS)
  ) u_coin (
    .dime_i    (dime_i),
    .quarter_i (quarter_i),
    .add_o     (coin_add)
  );

  toll_next_state #(
    .CREDIT_W      (CREDIT_W),
    .DIME_CENTS    (DIME_CENTS),
    .QUARTER_CENTS (QUARTER_CENTS),
    .TOLL_CENTS    (TOLL_CENTS)
  ) u_next (
    .state_q (state_q),
    .car_i   (car_i),
    .tag_i   (tag_i),
    .add_i   (coin_add),
    .state_d (state_d),
    .gate_o  (gate_raw)
  );

  toll_state_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_d (state_d),
    .state_q (state_q)
  );

  // No barrier command while reset is held.
  assign gate_o  = gate_raw & rst_ni;
  assign state_o = state_q;

endmodule

// File: rtl/toll_gate_ctrl_sva.sv
module toll_gate_ctrl_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       car_i,
  input logic       dime_i,
  input logic       quarter_i,
  input logic       tag_i,
  input logic       gate_o,
  input logic [2:0] state_o
);

  assert_gate_needs_car_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> car_i);

  assert_open_then_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |=> (state_o == 3'b000));

  assert_tag_opens_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_i && tag_i) |-> gate_o);

  assert_depart_to_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o != 3'b000) && !car_i) |=> (state_o == 3'b000));

  assert_idle_ignores_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'b000) && !car_i) |=> (state_o == 3'b000));

  assert_credit_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o != 3'b000) && car_i && !dime_i && !quarter_i && !tag_i) |=> $stable(state_o));

  assert_legal_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'b100);

endmodule

bind toll_gate_ctrl toll_gate_ctrl_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .car_i     (car_i),
  .dime_i    (dime_i),
  .quarter_i (quarter_i),
  .tag_i     (tag_i),
  .gate_o    (gate_o),
  .state_o   (state_o)
);

// File: tb/toll_gate_ctrl_bench.sv
module toll_gate_ctrl_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       car_i = 1'b0;
  logic       dime_i = 1'b0;
  logic       quarter_i = 1'b0;
  logic       tag_i = 1'b0;
  logic       gate_o;
  logic [2:0] state_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] S_IDLE = 3'b000;
  localparam logic [2:0] S_CAR0 = 3'b001;
  localparam logic [2:0] S_C10  = 3'b010;
  localparam logic [2:0] S_C20  = 3'b011;
  localparam logic [2:0] S_C25  = 3'b100;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  toll_gate_ctrl u_toll_gate_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .car_i     (car_i),
    .dime_i    (dime_i),
    .quarter_i (quarter_i),
    .tag_i     (tag_i),
    .gate_o    (gate_o),
    .state_o   (state_o)
  );

  task automatic check(input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs; check the Mealy gate before the edge
  // and the resulting state after it.
  task automatic apply(input string req, input logic c, input logic d,
                       input logic q, input logic t,
                       input logic exp_gate, input logic [2:0] exp_state);
    @(negedge clk_i);
    car_i = c; dime_i = d; quarter_i = q; tag_i = t;
    #1;
    check(req, "gate", {2'b00, gate_o}, {2'b00, exp_gate});
    @(posedge clk_i);
    #1;
    check(req, "state", state_o, exp_state);
  endtask

  task automatic t_reset_hold();
    @(negedge clk_i);
    car_i = 1'b1; tag_i = 1'b1;
    #1;
    check("R1", "gate in reset", {2'b00, gate_o}, 3'b000);
    check("R1", "state in reset", state_o, S_IDLE);
    @(negedge clk_i);
    car_i = 1'b0; tag_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic t_idle_ignore();
    apply("R2", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, S_IDLE);
    apply("R2", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, S_IDLE);
    apply("R10", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, S_IDLE);
    apply("R2", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, S_IDLE);
  endtask

  task automatic t_dimes();
    apply("R3", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, S_CAR0);
    apply("R3", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, S_CAR0);
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C10);
    apply("R3", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, S_C10);
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C20);
    apply("R8", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C25);
    apply("R8", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, S_IDLE);
  endtask

  task automatic t_quarters();
    apply("R4", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, S_C25);
    apply("R3", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, S_C25);
    apply("R6", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, S_IDLE);
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C10);
    apply("R6", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, S_IDLE);
  endtask

  task automatic t_both_coins();
    apply("R5", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, S_C25);
    apply("R5", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, S_IDLE);
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C10);
    apply("R5", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, S_IDLE);
  endtask

  task automatic t_tag();
    apply("R7", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, S_IDLE);
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C10);
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C20);
    apply("R7", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, S_IDLE);
  endtask

  task automatic t_depart();
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C10);
    apply("R9", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, S_IDLE);
    apply("R9", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, S_CAR0);
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C10);
    apply("R9", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C20);
    apply("R9", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, S_IDLE);
  endtask

  task automatic t_async_reset();
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C10);
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C20);
    @(negedge clk_i);
    car_i = 1'b1; dime_i = 1'b0; quarter_i = 1'b0; tag_i = 1'b0;
    #1;
    rst_ni = 1'b0;
    #1;
    check("R1", "async state", state_o, S_IDLE);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply("R1", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, S_C10);
    apply("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, S_IDLE);
  endtask

  initial begin
    t_reset_hold();
    t_idle_ignore();
    t_dimes();
    t_quarters();
    t_both_coins();
    t_tag();
    t_depart();
    t_async_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule